// File: doc/BRIEF.md
# Masked Pattern Trace Monitor

This block watches a 64-bit sample bus that carries a valid strobe. Two masked comparators look at each sample. Each comparator has its own pattern and mask, and software programs them separately. One comparator drives a timestamp-request pulse. The other drives a trigger pulse. The block also forwards samples to a downstream trace formatter. In continuous mode it forwards every valid sample. In change-only mode it drops any sample equal to the one it last forwarded.

Software uses a simple word-wide write port and a combinational read port. Through them it programs a control word, a timestamp-request enable, and four 64-bit banks. The banks are the timestamp pattern, the timestamp mask, the trigger pattern and the trigger mask. Each bank is split over two 32-bit words, and the word at the lower address holds bits 31:0. A mask bit of 1 makes the matching sample bit take part in the compare. A mask bit of 0 makes that bit a don't-care.

Top module: `trace_match_monitor`

## Requirements
- R1: After reset, every programmed word reads back as zero, and `trig_pulse`, `ts_req` and `fwd_valid` are low.
- R2: The register map is as follows.
  - 0xA00 is control: bit 0 is enable, bit 1 is mode. Other bits read back zero.
  - 0xA04 bit 0 is the timestamp-request enable.
  - 0xA08/0xA0C hold the timestamp pattern and 0xA10/0xA14 hold the timestamp mask.
  - 0xA18/0xA1C hold the trigger pattern and 0xA20/0xA24 hold the trigger mask.
  - Any other address reads zero.
- R3: A sample matches a comparator when every bit whose mask bit is 1 equals the pattern bit. Mask bits of 0 are ignored, so an all-zero mask matches every sample. The lower-address word of each pair covers bits 31:0.
- R4: `trig_pulse` is high for exactly the one cycle after each valid sample that matches the trigger comparator. It never pulses without a valid sample.
- R5: `ts_req` is high for the one cycle after each valid sample that matches the timestamp comparator, but only while the timestamp-request enable is set.
- R6: While the enable bit is 0, all three outputs stay low, whatever the samples are.
- R7: In continuous mode (mode 0), each valid sample gives `fwd_valid` high on the next cycle, with `fwd_data` equal to that sample.
- R8: In change-only mode (mode 1), a valid sample is forwarded only if it differs from the last forwarded sample. The first valid sample after the enable bit goes from 0 to 1 is always forwarded.
- R9: The two comparators are independent. A sample can raise either pulse alone or both pulses together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sample_valid | input | 1 | Sample strobe |
| sample_data | input | 64 | Sample value |
| trig_pulse | output | 1 | Trigger-match pulse |
| ts_req | output | 1 | Timestamp-request pulse |
| fwd_valid | output | 1 | Forwarded-sample strobe |
| fwd_data | output | 64 | Forwarded sample |

## Verification
A pattern or mask word stored in the wrong place, or held with the wrong bit order, shows up in two ways. The readback value is wrong straight away. The wrong pulse also appears, or goes missing, one cycle after the first sample that exercises that bit. If the change filter loses track of its last-sample state, the first repeated sample in change-only mode is forwarded when it should be dropped. Likewise, the first sample after a re-enable is dropped when it should be forwarded. Both errors appear at `fwd_valid` on the cycle after that sample. If enable gating fails, a pulse appears one cycle after a sample sent while the block is disabled.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  localparam int unsigned REG_AW  = 12;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_BANKS = 4;
  // Bank order: timestamp pattern, timestamp mask, trigger pattern, trigger mask
  localparam logic [REG_AW-1:0] OFS_CTRL  = 12'hA00;
  localparam logic [REG_AW-1:0] OFS_TSEN  = 12'hA04;
  localparam logic [REG_AW-1:0] OFS_BANK0 = 12'hA08;
  localparam int unsigned BANK_STRIDE = 8;
  localparam int unsigned WORD_BYTES  = WORD_W / 8;

  typedef enum logic {
    MODE_CONT   = 1'b0,
    MODE_CHANGE = 1'b1
  } fwd_mode_e;
endpackage

// File: rtl/tmm_regs.sv
module tmm_regs
  import tmm_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 en,
  output fwd_mode_e            mode,
  output logic                 ts_en,
  output logic [DATA_W-1:0]    ts_pat,
  output logic [DATA_W-1:0]    ts_msk,
  output logic [DATA_W-1:0]    tg_pat,
  output logic [DATA_W-1:0]    tg_msk
);
  localparam int unsigned NW   = DATA_W / WORD_W;
  localparam int unsigned NSLT = N_BANKS * NW;

  logic [N_BANKS-1:0][DATA_W-1:0] bank;
  logic [NSLT-1:0][WORD_W-1:0]    rd_part;

  logic            en_q, en_d;
  fwd_mode_e       mode_q, mode_d;
  logic            tsen_q, tsen_d;

  // control and timestamp-enable next state
  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    tsen_d = tsen_q;
    if (wr_en && addr == OFS_CTRL) begin
      en_d   = wdata[0];
      mode_d = fwd_mode_e'(wdata[1]);
    end
    if (wr_en && addr == OFS_TSEN) tsen_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_CONT;
      tsen_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      tsen_q <= tsen_d;
    end
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    for (genvar w = 0; w < NW; w++) begin : g_word
      localparam logic [REG_AW-1:0] A =
        OFS_BANK0 + REG_AW'(b * BANK_STRIDE + w * WORD_BYTES);
      logic [WORD_W-1:0] q, d;
      logic              hit;
      assign hit = (addr == A);
      always_comb d = (wr_en && hit) ? wdata : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign bank[b][w*WORD_W +: WORD_W] = q;
      assign rd_part[b*NW + w]           = hit ? q : '0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSLT; i++) rdata |= rd_part[i];
    if (addr == OFS_CTRL) rdata = {{(WORD_W-2){1'b0}}, mode_q, en_q};
    if (addr == OFS_TSEN) rdata = {{(WORD_W-1){1'b0}}, tsen_q};
  end

  assign en     = en_q;
  assign mode   = mode_q;
  assign ts_en  = tsen_q;
  assign ts_pat = bank[0];
  assign ts_msk = bank[1];
  assign tg_pat = bank[2];
  assign tg_msk = bank[3];
endmodule

// File: rtl/tmm_match.sv
module tmm_match #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] pat,
  input  logic [DATA_W-1:0] msk,
  output logic              hit
);
  assign hit = valid && (((data ^ pat) & msk) == '0);
endmodule

// File: rtl/tmm_fwd.sv
module tmm_fwd
  import tmm_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  fwd_mode_e         mode,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data,
  output logic              have_last
);
  logic              have_q, have_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              pass;

  // dat_q doubles as the last forwarded sample
  always_comb begin
    pass   = valid && (mode == MODE_CONT || !have_q || data != dat_q);
    vld_d  = en && pass;
    dat_d  = vld_d ? data : dat_q;
    have_d = en ? (have_q || pass) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      have_q <= have_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
    end
  end

  assign fwd_valid = vld_q;
  assign fwd_data  = dat_q;
  assign have_last = have_q;
endmodule

// File: rtl/trace_match_monitor.sv
module trace_match_monitor
  import tmm_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sample_valid,
  input  logic [63:0]       sample_data,
  output logic              trig_pulse,
  output logic              ts_req,
  output logic              fwd_valid,
  output logic [63:0]       fwd_data
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic              en_w, tsen_w, have_w;
  fwd_mode_e         mode_w;
  logic [DATA_W-1:0] ts_pat, ts_msk, tg_pat, tg_msk;
  logic              ts_hit, tg_hit;

  tmm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en(en_w), .mode(mode_w),
    .ts_en(tsen_w), .ts_pat(ts_pat), .ts_msk(ts_msk),
    .tg_pat(tg_pat), .tg_msk(tg_msk)
  );

  tmm_match #(.DATA_W(DATA_W)) u_ts_cmp (
    .valid(sample_valid), .data(sample_data), .pat(ts_pat), .msk(ts_msk),
    .hit(ts_hit)
  );

  tmm_match #(.DATA_W(DATA_W)) u_tg_cmp (
    .valid(sample_valid), .data(sample_data), .pat(tg_pat), .msk(tg_msk),
    .hit(tg_hit)
  );

  tmm_fwd #(.DATA_W(DATA_W)) u_fwd (
    .clk(clk), .rst_n(rst_core_n), .en(en_w), .mode(mode_w),
    .valid(sample_valid), .data(sample_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .have_last(have_w)
  );

  logic trig_q, trig_d, ts_q, ts_d;
  always_comb begin
    trig_d = en_w && tg_hit;
    ts_d   = en_w && tsen_w && ts_hit;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      trig_q <= 1'b0;
      ts_q   <= 1'b0;
    end else begin
      trig_q <= trig_d;
      ts_q   <= ts_d;
    end
  end

  assign trig_pulse = trig_q;
  assign ts_req     = ts_q;
endmodule

// File: rtl/tmm_checker.sv
module tmm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_valid,
  input logic [63:0] sample_data,
  input logic        en,
  input logic        mode,
  input logic        ts_en,
  input logic        have_last,
  input logic        trig_pulse,
  input logic        ts_req,
  input logic        fwd_valid,
  input logic [63:0] fwd_data
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(trig_pulse || ts_req || fwd_valid));  // R6

  AST_NO_SAMPLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !(trig_pulse || ts_req || fwd_valid));  // R4

  AST_TS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_en |=> !ts_req);  // R5

  AST_CONT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && sample_valid) |=>
      (fwd_valid && fwd_data == $past(sample_data)));  // R7

  AST_REPEAT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && sample_valid && have_last && sample_data == fwd_data)
      |=> !fwd_valid);  // R8
endmodule

bind trace_match_monitor tmm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
  .sample_data(sample_data), .en(en_w), .mode(mode_w), .ts_en(tsen_w),
  .have_last(have_w), .trig_pulse(trig_pulse), .ts_req(ts_req),
  .fwd_valid(fwd_valid), .fwd_data(fwd_data)
);

// File: tb/tb_trace_match_monitor.sv
`timescale 1ns/1ps
module tb_trace_match_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sample_valid = 1'b0;
  logic [63:0] sample_data = '0;
  logic        trig_pulse, ts_req, fwd_valid;
  logic [63:0] fwd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trace_match_monitor dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .trig_pulse(trig_pulse), .ts_req(ts_req),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp,
                        input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, req, $sformatf("read %h", a), 64'(reg_rdata), 64'(exp));
  endtask

  // one sample, then check the outputs on the following cycle
  task automatic samp(input logic v, input logic [63:0] d, input logic et,
                      input logic ets, input logic ef, input string req);
    @(negedge clk);
    sample_valid = v; sample_data = d;
    @(negedge clk);
    sample_valid = 1'b0;
    chk(trig_pulse === et, req, "trig_pulse", 64'(trig_pulse), 64'(et));
    chk(ts_req === ets, req, "ts_req", 64'(ts_req), 64'(ets));
    chk(fwd_valid === ef, req, "fwd_valid", 64'(fwd_valid), 64'(ef));
    if (ef) chk(fwd_data === d, req, "fwd_data", fwd_data, d);
  endtask

  // {data, valid, exp_trig, exp_ts, exp_fwd}; continuous mode, both comparators armed
  localparam int NV = 6;
  localparam logic [67:0] VEC [NV] = '{
    {64'h0000_0001_DEAD_BEEF, 4'b1011},
    {64'hA5A5_1234_DEAD_BEEF, 4'b1111},
    {64'hA5A5_0000_0000_0000, 4'b1101},
    {64'hA5A5_0000_DEAD_BEEF, 4'b0000},
    {64'h5A5A_0000_1111_2222, 4'b1001},
    {64'hA5A5_FFFF_DEAD_BEEE, 4'b1101}
  };

  localparam logic [63:0] X = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] Y = 64'h0123_4567_89AB_CDEE;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(!trig_pulse && !ts_req && !fwd_valid, "R1", "outputs after reset",
        {61'd0, trig_pulse, ts_req, fwd_valid}, 64'd0);
    rd_chk(12'hA00, 32'h0, "R1");
    rd_chk(12'hA08, 32'h0, "R1");
    rd_chk(12'hA24, 32'h0, "R1");

    // R2 register map and readback
    wr(12'hA00, 32'hFFFF_FFFC);
    rd_chk(12'hA00, 32'h0, "R2");
    wr(12'hA04, 32'h0000_0001);
    wr(12'hA08, 32'hDEAD_BEEF);
    wr(12'hA0C, 32'h0000_0000);
    wr(12'hA10, 32'hFFFF_FFFF);
    wr(12'hA14, 32'h0000_0000);
    wr(12'hA18, 32'h0000_0000);
    wr(12'hA1C, 32'hA5A5_0000);
    wr(12'hA20, 32'h0000_0000);
    wr(12'hA24, 32'hFFFF_0000);
    wr(12'hA28, 32'h1234_5678);
    rd_chk(12'hA04, 32'h1, "R2");
    rd_chk(12'hA08, 32'hDEAD_BEEF, "R2");
    rd_chk(12'hA10, 32'hFFFF_FFFF, "R2");
    rd_chk(12'hA1C, 32'hA5A5_0000, "R2");
    rd_chk(12'hA24, 32'hFFFF_0000, "R2");
    rd_chk(12'hA28, 32'h0, "R2");
    rd_chk(12'h000, 32'h0, "R2");

    // R6 disabled: matching sample gives nothing
    samp(1'b1, 64'hA5A5_0000_DEAD_BEEF, 1'b0, 1'b0, 1'b0, "R6");

    wr(12'hA00, 32'h1);
    rd_chk(12'hA00, 32'h1, "R2");
    // R3 R4 R5 R7 R9 table walk
    for (int i = 0; i < NV; i++)
      samp(VEC[i][3], VEC[i][67:4], VEC[i][2], VEC[i][1], VEC[i][0],
           "R3/R4/R5/R7/R9 table");

    // R5 timestamp enable off
    wr(12'hA04, 32'h0);
    samp(1'b1, 64'hA5A5_0000_DEAD_BEEF, 1'b1, 1'b0, 1'b1, "R5");
    wr(12'hA04, 32'h1);

    // R3 all-zero mask matches everything
    wr(12'hA24, 32'h0);
    samp(1'b1, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 1'b1, "R3");

    // R8 change-only mode
    wr(12'hA00, 32'h3);
    samp(1'b1, X, 1'b1, 1'b0, 1'b1, "R8 first");
    samp(1'b1, X, 1'b1, 1'b0, 1'b0, "R8 repeat");
    samp(1'b1, Y, 1'b1, 1'b0, 1'b1, "R8 change");
    samp(1'b1, Y, 1'b1, 1'b0, 1'b0, "R8 repeat");
    samp(1'b1, X, 1'b1, 1'b0, 1'b1, "R8 back");
    wr(12'hA00, 32'h2);
    samp(1'b1, X, 1'b0, 1'b0, 1'b0, "R6 disabled");
    wr(12'hA00, 32'h3);
    samp(1'b1, X, 1'b1, 1'b0, 1'b1, "R8 first after re-enable");

    // R1 reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!trig_pulse && !ts_req && !fwd_valid, "R1", "outputs in reset",
        {61'd0, trig_pulse, ts_req, fwd_valid}, 64'd0);
    rd_chk(12'hA1C, 32'h0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk(12'hA00, 32'h0, "R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule